// File: doc/BRIEF.md
# Zero-turnaround pipelined burst SRAM

This block is a synthesizable model of a synchronous static RAM whose data bus never idles when traffic switches between reads and writes. Each command (address, direction and select inputs) is registered on a rising clock edge. The data for that command moves two clocks later. This holds for reads and for writes, so any mix of commands can be issued back to back. The data bus is split into an input word, an output word and an output-drive flag, which a board-level wrapper or a bus fabric can turn into a shared bus.

An internal two-bit beat counter lets a single loaded address produce four data beats. The beats follow either a linear or an interleaved order, chosen by a static input. Writes are masked per 9-bit lane (8 data bits and 1 parity bit). Three select inputs gate new commands. A stall input freezes the whole pipeline. An asynchronous output-enable input can release the bus at any time.

Top module: `zbt_burst_sram`

## Requirements
- R1: A command registered at edge E0 owns the bus cycle between edges E2 and E3. A read drives `dout` with `dout_en` high during that cycle only. A write samples `din` and `lane_we_n` at edge E3 and keeps `dout_en` low during that cycle.
- R2: Reads and writes may be issued on consecutive edges in any mix. A read of the word written by the command one edge earlier returns the newly written lanes merged with the old contents of the other lanes.
- R3: Lane i holds bits [9i+8:9i]. A write changes lane i only when `lane_we_n[i]` is low in the data cycle. Lanes whose bit is high keep their previous contents.
- R4: With `burst_adv` low, `addr` is loaded and used for this beat. With `burst_adv` high, the next beat is issued. In linear order (`ilv_order`=0), beat n uses low address bits (start + n) mod 4.
- R5: In interleaved order (`ilv_order`=1), beat n uses low address bits start XOR n. In both orders the upper address bits stay those of the loaded address, and the sequence starts over after four beats.
- R6: A beat issued with `burst_adv` high keeps the direction of the loading command. During such a beat, `rd_nwr` and the three selects are ignored.
- R7: A command is accepted only when `burst_adv` is low, `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A rejected command writes nothing and leaves `dout_en` low in its data cycle.
- R8: Commands already accepted complete their data cycles even when the commands that follow are deselected.
- R9: While `stall` is high, the block ignores every synchronous input, performs no memory write, and holds `dout`, `dout_en` and all pipeline state. Data cycles move later by the number of stalled edges.
- R10: `oe_n` high forces `dout_en` low at once, without waiting for a clock edge.
- R11: Synchronous `rst` cancels all commands in flight and leaves `dout_en` low. Memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | High freezes the entire pipeline |
| sel_a_n | input | 1 | Active-low select |
| sel_b | input | 1 | Active-high select |
| sel_c_n | input | 1 | Active-low select |
| burst_adv | input | 1 | Low: load `addr`; high: issue next beat |
| rd_nwr | input | 1 | High read, low write (load cycles only) |
| addr | input | ADDR_W | Word address |
| ilv_order | input | 1 | Beat order: 0 linear, 1 interleaved |
| lane_we_n | input | LANES | Active-low lane write masks, sampled in the data cycle |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data |
| dout_en | output | 1 | High while `dout` should drive the bus |

## Verification
Two functions can land on the same edge: the memory commit of a write, and the array read for a read of the same word issued one edge later. The bench provokes this by issuing write-then-read pairs to one address on consecutive edges, with both full and partial lane masks. It judges the read data against a merge of the old and new words that the bench computes itself. A stall is also placed on the edge where a write's data cycle would close, to confirm that the commit moves later together with its data.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  localparam int BEAT_BITS = 2;

  // low address bits of beat n for a burst that started at 'start'
  function automatic logic [BEAT_BITS-1:0] beat_low(
    input logic [BEAT_BITS-1:0] start,
    input logic [BEAT_BITS-1:0] n,
    input burst_order_e         ord
  );
    if (ord == ORD_INTERLEAVE) return start ^ n;
    return start + n;
  endfunction

endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq
  import zbt_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic          sel_c_n,
  input  logic          burst_adv,
  input  logic          rd_nwr,
  input  logic [AW-1:0] addr,
  input  logic          ilv_order,
  output logic          s1_vld,
  output logic          s1_rd,
  output logic [AW-1:0] s1_addr
);

  logic [AW-1:0]        base_q;
  logic [BEAT_BITS-1:0] beat_q;
  logic                 dir_q;
  logic                 act_q;

  logic                 sel_all;
  logic [BEAT_BITS-1:0] beat_nx;
  logic [BEAT_BITS-1:0] step_low;

  always_comb begin
    sel_all  = !sel_a_n && sel_b && !sel_c_n;
    beat_nx  = beat_q + 2'd1;
    step_low = beat_low(base_q[BEAT_BITS-1:0], beat_nx, burst_order_e'(ilv_order));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      beat_q  <= '0;
      dir_q   <= 1'b0;
      act_q   <= 1'b0;
      s1_vld  <= 1'b0;
      s1_rd   <= 1'b0;
      s1_addr <= '0;
    end else if (!stall) begin
      if (!burst_adv) begin
        base_q  <= addr;
        beat_q  <= '0;
        dir_q   <= rd_nwr;
        act_q   <= sel_all;
        s1_vld  <= sel_all;
        s1_rd   <= rd_nwr;
        s1_addr <= addr;
      end else begin
        beat_q  <= beat_nx;
        s1_vld  <= act_q;
        s1_rd   <= dir_q;
        s1_addr <= {base_q[AW-1:BEAT_BITS], step_low};
      end
    end
  end

  // R5: a continuing beat never leaves the loaded row of four words
  p_row_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    (burst_adv && !stall) |=> (s1_addr[AW-1:BEAT_BITS] == $past(s1_addr[AW-1:BEAT_BITS])));

  // R6: a continuing beat keeps the direction already in flight
  p_dir_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (burst_adv && !stall) |=> (s1_rd == $past(s1_rd)));

endmodule

// File: rtl/zbt_lane_ram.sv
module zbt_lane_ram #(
  parameter int AW = 9,
  parameter int W  = 9
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rd_q
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[waddr] <= wdata;
      if (re) rd_q <= (we && (waddr == raddr)) ? wdata : mem[raddr];
    end
  end

endmodule

// File: rtl/zbt_burst_sram.sv
module zbt_burst_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    stall,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    burst_adv,
  input  logic                    rd_nwr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ilv_order,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);

  localparam int WORD_W = LANES * LANE_W;

  logic              s1_vld, s1_rd;
  logic [ADDR_W-1:0] s1_addr;
  logic              s2_vld, s2_rd;
  logic [ADDR_W-1:0] s2_addr;
  logic              s3_wr;
  logic [ADDR_W-1:0] s3_addr;
  logic              drive_q;
  logic [WORD_W-1:0] rd_word;
  logic              rd_go;

  zbt_burst_seq #(.AW(ADDR_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .sel_a_n   (sel_a_n),
    .sel_b     (sel_b),
    .sel_c_n   (sel_c_n),
    .burst_adv (burst_adv),
    .rd_nwr    (rd_nwr),
    .addr      (addr),
    .ilv_order (ilv_order),
    .s1_vld    (s1_vld),
    .s1_rd     (s1_rd),
    .s1_addr   (s1_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld  <= 1'b0;
      s2_rd   <= 1'b0;
      s2_addr <= '0;
      s3_wr   <= 1'b0;
      s3_addr <= '0;
      drive_q <= 1'b0;
    end else if (!stall) begin
      s2_vld  <= s1_vld;
      s2_rd   <= s1_rd;
      s2_addr <= s1_addr;
      s3_wr   <= s2_vld && !s2_rd;
      s3_addr <= s2_addr;
      drive_q <= s2_vld && s2_rd;
    end
  end

  assign rd_go = s2_vld && s2_rd;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    zbt_lane_ram #(.AW(ADDR_W), .W(LANE_W)) u_ram (
      .clk   (clk),
      .en    (!stall),
      .we    (s3_wr && !lane_we_n[i]),
      .waddr (s3_addr),
      .wdata (din[i*LANE_W +: LANE_W]),
      .re    (rd_go),
      .raddr (s2_addr),
      .rd_q  (rd_word[i*LANE_W +: LANE_W])
    );
  end

  assign dout    = rd_word;
  assign dout_en = drive_q && !oe_n;

  // R1: an accepted read owns the bus two unstalled edges after capture
  p_read_slot_r1: assert property (@(posedge clk) disable iff (rst)
    (!stall && !burst_adv && !sel_a_n && sel_b && !sel_c_n && rd_nwr)
      ##1 !stall ##1 !stall |=> drive_q);

  // R1: the data cycle of an accepted write is never driven
  p_write_slot_r1: assert property (@(posedge clk) disable iff (rst)
    (!stall && !burst_adv && !sel_a_n && sel_b && !sel_c_n && !rd_nwr)
      ##1 !stall ##1 !stall |=> !drive_q);

  // R9: a stalled edge leaves the drive flag unchanged
  p_stall_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (!rst && stall) |=> $stable(drive_q));

  // R9: a stalled edge leaves driven read data unchanged
  p_stall_data_r9: assert property (@(posedge clk) disable iff (rst)
    (!rst && stall && drive_q) |=> $stable(dout));

endmodule

// File: tb/zbt_burst_sram_test.sv
module zbt_burst_sram_test;

  localparam int AW = 9;
  localparam int WW = 36;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stall = 1'b0;
  logic          sel_a_n = 1'b1;
  logic          sel_b = 1'b0;
  logic          sel_c_n = 1'b1;
  logic          burst_adv = 1'b0;
  logic          rd_nwr = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          ilv_order = 1'b0;
  logic [3:0]    lane_we_n = 4'hF;
  logic          oe_n = 1'b0;
  logic [WW-1:0] din = '0;
  logic [WW-1:0] dout;
  logic          dout_en;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [WW-1:0] wd_s [64];
  logic [3:0]    wl_s [64];
  bit            ex_en [64];
  logic [WW-1:0] ex_d [64];
  string         ex_tag [64];

  always #5 clk = ~clk;

  zbt_burst_sram uut (
    .clk(clk), .rst(rst), .stall(stall), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .burst_adv(burst_adv), .rd_nwr(rd_nwr), .addr(addr),
    .ilv_order(ilv_order), .lane_we_n(lane_we_n), .oe_n(oe_n), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [WW-1:0] pat(input logic [AW-1:0] a);
    return {4'hA, 1'b0, a, 2'b01, ~a, 2'b10, a};
  endfunction

  function automatic logic [WW-1:0] merge(input logic [WW-1:0] old_w,
                                          input logic [WW-1:0] new_w,
                                          input logic [3:0] mask_n);
    logic [WW-1:0] r;
    r = old_w;
    for (int i = 0; i < 4; i++)
      if (!mask_n[i]) r[i*9 +: 9] = new_w[i*9 +: 9];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (slot %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic put_wr(input int slot, input logic [WW-1:0] d, input logic [3:0] m);
    wd_s[slot % 64] = d;
    wl_s[slot % 64] = m;
  endtask

  task automatic exp_rd(input int slot, input logic [WW-1:0] d, input string tag);
    ex_en[slot % 64]  = 1'b1;
    ex_d[slot % 64]   = d;
    ex_tag[slot % 64] = tag;
  endtask

  // one clock: apply inputs after a falling edge, check the state after the next rising edge
  task automatic tick(input bit st, input bit an, input bit b, input bit cn,
                      input bit adv, input bit rw, input logic [AW-1:0] a);
    int s;
    s = cyc % 64;
    stall = st; sel_a_n = an; sel_b = b; sel_c_n = cn;
    burst_adv = adv; rd_nwr = rw; addr = a;
    din = wd_s[s]; lane_we_n = wl_s[s];
    wl_s[s] = 4'hF;
    @(posedge clk);
    @(negedge clk);
    chk(dout_en === ex_en[s], ex_tag[s], {35'd0, dout_en}, {35'd0, ex_en[s]});
    if (ex_en[s]) chk(dout === ex_d[s], ex_tag[s], dout, ex_d[s]);
    ex_en[s] = 1'b0;
    ex_tag[s] = "R1";
    cyc++;
  endtask

  task automatic cmd_wr(input logic [AW-1:0] a); tick(0, 0, 1, 0, 0, 0, a); endtask
  task automatic cmd_rd(input logic [AW-1:0] a); tick(0, 0, 1, 0, 0, 1, a); endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 1, 0, 1, 0, 1, '0);
  endtask
  // continuing beat with selects off and the direction pin set to 'other'
  task automatic beat(input bit other); tick(0, 1, 0, 1, 1, other, '0); endtask

  logic [WW-1:0] d1, d2, d3;

  task automatic t_single();
    int c;
    c = cyc;
    put_wr(c + 3, pat(5), 4'h0);
    cmd_wr(5);
    idle(3);
    c = cyc;
    exp_rd(c + 2, pat(5), "R1");
    cmd_rd(5);
    idle(4);
  endtask

  task automatic t_turnaround();
    int c;
    d1 = 36'h1_2345_6789; d2 = 36'hF_EDCB_A987; d3 = 36'h5_5AA5_5AA5;
    c = cyc;
    put_wr(c + 3, d1, 4'h0);
    exp_rd(c + 3, d1, "R2");
    put_wr(c + 5, d2, 4'h0);
    exp_rd(c + 5, d2, "R2");
    exp_rd(c + 6, d1, "R2");
    put_wr(c + 8, d3, 4'b1010);
    exp_rd(c + 8, merge(d1, d3, 4'b1010), "R3");
    cmd_wr(20); cmd_rd(20); cmd_wr(21); cmd_rd(21); cmd_rd(20);
    cmd_wr(20); cmd_rd(20);
    idle(3);
    c = cyc;
    exp_rd(c + 2, merge(d1, d3, 4'b1010), "R3");
    cmd_rd(20);
    idle(3);
  endtask

  task automatic t_burst_read();
    int c;
    c = cyc;
    for (int i = 0; i < 4; i++) put_wr(c + 3 + i, pat(AW'(8 + i)), 4'h0);
    for (int i = 0; i < 4; i++) cmd_wr(AW'(8 + i));
    idle(4);
    ilv_order = 1'b0;
    c = cyc;
    exp_rd(c + 2, pat(9), "R4");
    exp_rd(c + 3, pat(10), "R4");
    exp_rd(c + 4, pat(11), "R4");
    exp_rd(c + 5, pat(8), "R4");
    exp_rd(c + 6, pat(9), "R5");
    cmd_rd(9); beat(0); beat(0); beat(0); beat(0);
    idle(3);
    ilv_order = 1'b1;
    c = cyc;
    exp_rd(c + 2, pat(9), "R5");
    exp_rd(c + 3, pat(8), "R5");
    exp_rd(c + 4, pat(11), "R5");
    exp_rd(c + 5, pat(10), "R5");
    cmd_rd(9); beat(0); beat(0); beat(0);
    idle(3);
    ilv_order = 1'b0;
  endtask

  task automatic t_burst_write();
    int c;
    logic [AW-1:0] seq [4];
    seq[0] = 14; seq[1] = 15; seq[2] = 12; seq[3] = 13;
    c = cyc;
    for (int i = 0; i < 4; i++) put_wr(c + 3 + i, ~pat(seq[i]), 4'h0);
    cmd_wr(14); beat(1); beat(1); beat(1);
    idle(4);
    c = cyc;
    for (int i = 0; i < 4; i++) exp_rd(c + 2 + i, ~pat(AW'(12 + i)), "R6");
    for (int i = 0; i < 4; i++) cmd_rd(AW'(12 + i));
    idle(3);
  endtask

  task automatic t_deselect();
    int c;
    c = cyc;
    put_wr(c + 3, 36'h0, 4'h0);
    put_wr(c + 4, 36'h0, 4'h0);
    put_wr(c + 5, 36'h0, 4'h0);
    ex_tag[(c + 2) % 64] = "R7";
    ex_tag[(c + 3) % 64] = "R7";
    ex_tag[(c + 4) % 64] = "R7";
    tick(0, 0, 0, 0, 0, 0, 20);
    tick(0, 1, 1, 0, 0, 0, 21);
    tick(0, 0, 1, 1, 0, 0, 8);
    idle(4);
    c = cyc;
    exp_rd(c + 2, merge(d1, d3, 4'b1010), "R7");
    exp_rd(c + 3, d2, "R7");
    exp_rd(c + 4, pat(8), "R7");
    cmd_rd(20); cmd_rd(21); cmd_rd(8);
    idle(3);
    // accepted commands finish behind deselected ones
    c = cyc;
    exp_rd(c + 2, d2, "R8");
    put_wr(c + 4, 36'h3_1415_9265, 4'h0);
    cmd_rd(21); cmd_wr(22);
    idle(4);
    c = cyc;
    exp_rd(c + 2, 36'h3_1415_9265, "R8");
    cmd_rd(22);
    idle(3);
  endtask

  task automatic t_stall();
    int c;
    c = cyc;
    exp_rd(c + 3, pat(8), "R9");
    ex_tag[(c + 2) % 64] = "R9";
    put_wr(c + 1, 36'h0, 4'h0);
    cmd_rd(8);
    tick(1, 0, 1, 0, 0, 0, 8);
    idle(4);
    c = cyc;
    exp_rd(c + 2, pat(8), "R9");
    cmd_rd(8);
    idle(3);
    c = cyc;
    exp_rd(c + 2, pat(9), "R9");
    exp_rd(c + 3, pat(9), "R9");
    exp_rd(c + 4, pat(10), "R9");
    cmd_rd(9); cmd_rd(10); idle(1);
    tick(1, 1, 0, 1, 0, 1, '0);
    idle(3);
    c = cyc;
    put_wr(c + 3, 36'h0, 4'h0);
    put_wr(c + 4, 36'h7_0F0F_0F0F, 4'h0);
    cmd_wr(11); idle(2);
    tick(1, 1, 0, 1, 0, 1, '0);
    idle(3);
    c = cyc;
    exp_rd(c + 2, 36'h7_0F0F_0F0F, "R9");
    cmd_rd(11);
    idle(3);
  endtask

  task automatic t_oe();
    cmd_rd(10);
    exp_rd(cyc + 1, pat(10), "R10");
    idle(2);
    oe_n = 1'b1;
    #1;
    chk(dout_en === 1'b0, "R10", {35'd0, dout_en}, 36'd0);
    oe_n = 1'b0;
    #1;
    chk(dout_en === 1'b1, "R10", {35'd0, dout_en}, 36'd1);
    idle(2);
  endtask

  task automatic t_reset();
    int c;
    c = cyc;
    ex_tag[(c + 2) % 64] = "R11";
    ex_tag[(c + 3) % 64] = "R11";
    cmd_rd(5);
    rst = 1'b1;
    idle(1);
    rst = 1'b0;
    idle(3);
    c = cyc;
    exp_rd(c + 2, pat(5), "R11");
    cmd_rd(5);
    idle(3);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      wd_s[i] = '0; wl_s[i] = 4'hF; ex_en[i] = 1'b0; ex_d[i] = '0; ex_tag[i] = "R1";
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dout_en === 1'b0, "R11", {35'd0, dout_en}, 36'd0);
    t_single();
    t_turnaround();
    t_burst_read();
    t_burst_write();
    t_deselect();
    t_stall();
    t_oe();
    t_reset();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule